// File: doc/BRIEF.md
# Instruction prefix merging decoder

This decode-stage block looks at a fetch window of up to three 32-bit words and folds any leading prefix words into the instruction that follows them. A prefix word has no operation of its own. It marks itself with a reserved major opcode and carries payload bits that widen the immediate of the next real instruction. The block resolves the prefix chain, the bundle length and the widened immediate together. It hands the base decoder one bundle per window, with flags saying how many prefixes were folded in.

Word 0 of the window (`win_data[31:0]`) is first in program order. `win_words` says how many words, counted from word 0, hold fetched data. The result is registered and appears one clock after the window is sampled. Opcode decoding of the base instruction is left to the base decoder. This block only extracts the base immediate from bits [31:20] of the base word.

Top module: `pmd_prefix_merge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_vld`, `out_illegal`, `out_len`, `out_pfx_cnt` and `out_imm` are all zero.
- R2: A word whose bits [31:24] equal 8'hFB is a prefix, and its bits [23:0] are its payload. Any other value in bits [31:24] makes the word a base instruction.
- R3: If word 0 is a base instruction and `win_words` >= 1, the result has `out_vld`=1, `out_len`=1 (32 bits) and `out_pfx_cnt`=0. `out_imm` is word 0 bits [31:20] sign-extended to 64 bits.
- R4: If word 0 is a prefix, word 1 is a base instruction and `win_words` >= 2, the result has `out_vld`=1, `out_len`=2 (64 bits) and `out_pfx_cnt`=1. `out_imm` is the 36-bit value {payload0, word1[31:20]} sign-extended to 64 bits.
- R5: If words 0 and 1 are prefixes, word 2 is a base instruction and `win_words`=3, the result has `out_vld`=1, `out_len`=3 (96 bits) and `out_pfx_cnt`=2. `out_imm` is the 60-bit value {payload0, payload1, word2[31:20]} sign-extended to 64 bits, so the first prefix supplies the most significant bits.
- R6: A window of three valid words that are all prefixes gives `out_illegal`=1 and `out_vld`=0.
- R7: A window whose valid words end in a prefix with no base instruction after it gives `out_illegal`=1 and `out_vld`=0. A `win_words` value of 0 with `win_vld`=1 is treated the same way. On an illegal result `out_len`, `out_pfx_cnt` and `out_imm` are zero.
- R8: When `win_vld` is 0, the next result has `out_vld`=0, `out_illegal`=0 and all other outputs zero.
- R9: Each result reflects the window sampled at the previous rising clock edge. `out_vld` and `out_illegal` are never both 1.
- R10: Words after the base instruction, and words at or beyond index `win_words`, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| win_vld | input | 1 | Fetch window present this cycle |
| win_words | input | 2 | Number of valid words in the window, from word 0 |
| win_data | input | 96 | Window data, word 0 in bits [31:0] |
| out_vld | output | 1 | Legal bundle decoded |
| out_illegal | output | 1 | Window holds an illegal prefix arrangement |
| out_len | output | 2 | Bundle length in 32-bit words (1, 2 or 3) |
| out_pfx_cnt | output | 2 | Number of prefixes merged into the bundle |
| out_imm | output | 64 | Merged, sign-extended immediate |

## Verification
Each result is due one rising edge after its window is presented, because a single output register follows the combinational merge. The bench drives a window on a falling edge and lets one rising edge capture it. It reads every output at the next falling edge, half a period clear of any edge, and only then drives the next window. The sweep covers every prefix pattern against every valid-word count and several payloads of both signs. For each case the bench computes the expected length, flags and immediate with fixed-width arithmetic of its own.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

   typedef enum logic [1:0] {
      PMD_ST_NONE = 2'd0,
      PMD_ST_GOOD = 2'd1,
      PMD_ST_BAD  = 2'd2
   } pmd_status_e;

   localparam int unsigned PMD_WORD_W    = 32;
   localparam int unsigned PMD_OPC_W     = 8;
   localparam logic [7:0]  PMD_PFX_OPC   = 8'hFB;
   localparam int unsigned PMD_BIMM_W    = 12;
   localparam int unsigned PMD_BIMM_LSB  = 20;

endpackage

// File: rtl/pmd_word_class.sv
module pmd_word_class #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned OPC_W    = 8,
   parameter logic [OPC_W-1:0] PFX_OPC = 8'hFB,
   parameter int unsigned BIMM_W   = 12,
   parameter int unsigned BIMM_LSB = 20,
   localparam int unsigned PAY_W   = WORD_W - OPC_W
) (
   input  logic [WORD_W-1:0] word,
   output logic              is_pfx,
   output logic [PAY_W-1:0]  payload,
   output logic [BIMM_W-1:0] base_imm
);

   assign is_pfx   = (word[WORD_W-1 -: OPC_W] == PFX_OPC);
   assign payload  = word[PAY_W-1:0];
   assign base_imm = word[BIMM_LSB +: BIMM_W];

endmodule

// File: rtl/pmd_chain.sv
module pmd_chain
   import pmd_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 3,
   localparam int unsigned CNT_W    = $clog2(NUM_WORDS + 1)
) (
   input  logic                 win_vld,
   input  logic [CNT_W-1:0]     win_words,
   input  logic [NUM_WORDS-1:0] is_pfx,
   output pmd_status_e          status,
   output logic [CNT_W-1:0]     lead_cnt
);

   logic found;

   always_comb begin
      found    = 1'b0;
      lead_cnt = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (!found && (i < int'(win_words)) && !is_pfx[i]) begin
            found    = 1'b1;
            lead_cnt = CNT_W'(i);
         end
      end
      if (!win_vld)   status = PMD_ST_NONE;
      else if (found) status = PMD_ST_GOOD;
      else            status = PMD_ST_BAD;
   end

endmodule

// File: rtl/pmd_imm_merge.sv
module pmd_imm_merge #(
   parameter int unsigned NUM_WORDS = 3,
   parameter int unsigned PAY_W     = 24,
   parameter int unsigned BIMM_W    = 12,
   parameter int unsigned IMM_W     = 64,
   localparam int unsigned CNT_W    = $clog2(NUM_WORDS + 1)
) (
   input  logic [NUM_WORDS*PAY_W-1:0]  pay_flat,
   input  logic [NUM_WORDS*BIMM_W-1:0] bimm_flat,
   input  logic [CNT_W-1:0]            lead_cnt,
   output logic [IMM_W-1:0]            imm
);

   logic [IMM_W-1:0] cand [NUM_WORDS];

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_cand
      localparam int unsigned WK = k * PAY_W + BIMM_W;
      logic [WK-1:0] raw;
      always_comb begin
         raw = '0;
         for (int j = 0; j < k; j++) begin
            raw[WK-1 - j*PAY_W -: PAY_W] = pay_flat[j*PAY_W +: PAY_W];
         end
         raw[BIMM_W-1:0] = bimm_flat[k*BIMM_W +: BIMM_W];
      end
      assign cand[k] = {{(IMM_W-WK){raw[WK-1]}}, raw};
   end

   always_comb begin
      imm = '0;
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (int'(lead_cnt) == k) imm = cand[k];
      end
   end

endmodule

// File: rtl/pmd_prefix_merge.sv
module pmd_prefix_merge
   import pmd_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 3,
   parameter int unsigned WORD_W    = PMD_WORD_W,
   parameter int unsigned OPC_W     = PMD_OPC_W,
   parameter logic [OPC_W-1:0] PFX_OPC = PMD_PFX_OPC,
   parameter int unsigned BIMM_W    = PMD_BIMM_W,
   parameter int unsigned BIMM_LSB  = PMD_BIMM_LSB,
   parameter int unsigned IMM_W     = 64,
   localparam int unsigned PAY_W    = WORD_W - OPC_W,
   localparam int unsigned CNT_W    = $clog2(NUM_WORDS + 1),
   localparam int unsigned WIN_W    = NUM_WORDS * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_vld,
   input  logic [CNT_W-1:0] win_words,
   input  logic [WIN_W-1:0] win_data,
   output logic             out_vld,
   output logic             out_illegal,
   output logic [CNT_W-1:0] out_len,
   output logic [CNT_W-1:0] out_pfx_cnt,
   output logic [IMM_W-1:0] out_imm
);

   if (NUM_WORDS < 1) begin : g_bad_words
      $error("pmd_prefix_merge: NUM_WORDS must be at least 1");
   end
   if (OPC_W >= WORD_W) begin : g_bad_opc
      $error("pmd_prefix_merge: OPC_W must be narrower than WORD_W");
   end
   if (BIMM_LSB + BIMM_W > WORD_W) begin : g_bad_bimm
      $error("pmd_prefix_merge: base immediate field exceeds the word");
   end
   if ((NUM_WORDS - 1) * PAY_W + BIMM_W >= IMM_W) begin : g_bad_imm
      $error("pmd_prefix_merge: IMM_W too narrow for the longest bundle");
   end

   logic [NUM_WORDS-1:0]        is_pfx;
   logic [NUM_WORDS*PAY_W-1:0]  pay_flat;
   logic [NUM_WORDS*BIMM_W-1:0] bimm_flat;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      pmd_word_class #(
         .WORD_W   (WORD_W),
         .OPC_W    (OPC_W),
         .PFX_OPC  (PFX_OPC),
         .BIMM_W   (BIMM_W),
         .BIMM_LSB (BIMM_LSB)
      ) u_cls (
         .word     (win_data[w*WORD_W +: WORD_W]),
         .is_pfx   (is_pfx[w]),
         .payload  (pay_flat[w*PAY_W +: PAY_W]),
         .base_imm (bimm_flat[w*BIMM_W +: BIMM_W])
      );
   end

   pmd_status_e      status;
   logic [CNT_W-1:0] lead_cnt;
   logic [IMM_W-1:0] imm_c;

   pmd_chain #(
      .NUM_WORDS (NUM_WORDS)
   ) u_chain (
      .win_vld   (win_vld),
      .win_words (win_words),
      .is_pfx    (is_pfx),
      .status    (status),
      .lead_cnt  (lead_cnt)
   );

   pmd_imm_merge #(
      .NUM_WORDS (NUM_WORDS),
      .PAY_W     (PAY_W),
      .BIMM_W    (BIMM_W),
      .IMM_W     (IMM_W)
   ) u_imm (
      .pay_flat  (pay_flat),
      .bimm_flat (bimm_flat),
      .lead_cnt  (lead_cnt),
      .imm       (imm_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld     <= 1'b0;
         out_illegal <= 1'b0;
         out_len     <= '0;
         out_pfx_cnt <= '0;
         out_imm     <= '0;
      end else begin
         out_vld     <= (status == PMD_ST_GOOD);
         out_illegal <= (status == PMD_ST_BAD);
         if (status == PMD_ST_GOOD) begin
            out_len     <= lead_cnt + CNT_W'(1);
            out_pfx_cnt <= lead_cnt;
            out_imm     <= imm_c;
         end else begin
            out_len     <= '0;
            out_pfx_cnt <= '0;
            out_imm     <= '0;
         end
      end
   end

endmodule

// File: rtl/pmd_prefix_merge_chk.sv
module pmd_prefix_merge_chk #(
   parameter int unsigned NUM_WORDS = 3,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned OPC_W     = 8,
   parameter logic [OPC_W-1:0] PFX_OPC = 8'hFB,
   parameter int unsigned BIMM_W    = 12,
   parameter int unsigned IMM_W     = 64,
   localparam int unsigned CNT_W    = $clog2(NUM_WORDS + 1),
   localparam int unsigned WIN_W    = NUM_WORDS * WORD_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             win_vld,
   input logic [CNT_W-1:0] win_words,
   input logic [WIN_W-1:0] win_data,
   input logic             out_vld,
   input logic             out_illegal,
   input logic [CNT_W-1:0] out_len,
   input logic [CNT_W-1:0] out_pfx_cnt,
   input logic [IMM_W-1:0] out_imm
);

   logic all_pfx;
   logic w0_base;

   always_comb begin
      all_pfx = 1'b1;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (win_data[i*WORD_W + WORD_W - 1 -: OPC_W] != PFX_OPC) all_pfx = 1'b0;
      end
      w0_base = (win_data[WORD_W-1 -: OPC_W] != PFX_OPC);
   end

   AST_VLD_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_vld && out_illegal)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !win_vld |=> (!out_vld && !out_illegal && out_imm == '0)); // R8

   AST_ALL_PFX_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (win_vld && int'(win_words) == NUM_WORDS && all_pfx) |=> (out_illegal && !out_vld)); // R6

   AST_NO_PFX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (win_vld && win_words != '0 && w0_base) |=> (out_vld && out_len == CNT_W'(1) && out_pfx_cnt == '0)); // R3

   AST_LEN_TRACKS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_len == out_pfx_cnt + CNT_W'(1))); // R5

   AST_ILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_len == '0 && out_pfx_cnt == '0 && out_imm == '0)); // R7

   AST_BASE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_pfx_cnt == '0) |-> (out_imm[IMM_W-1:BIMM_W-1] == '0 || out_imm[IMM_W-1:BIMM_W-1] == '1)); // R3

endmodule

bind pmd_prefix_merge pmd_prefix_merge_chk #(
   .NUM_WORDS (NUM_WORDS),
   .WORD_W    (WORD_W),
   .OPC_W     (OPC_W),
   .PFX_OPC   (PFX_OPC),
   .BIMM_W    (BIMM_W),
   .IMM_W     (IMM_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .win_vld     (win_vld),
   .win_words   (win_words),
   .win_data    (win_data),
   .out_vld     (out_vld),
   .out_illegal (out_illegal),
   .out_len     (out_len),
   .out_pfx_cnt (out_pfx_cnt),
   .out_imm     (out_imm)
);

// File: tb/sim_pmd_prefix_merge.sv
module sim_pmd_prefix_merge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_vld = 1'b0;
   logic [1:0]  win_words = '0;
   logic [95:0] win_data = '0;
   logic        out_vld, out_illegal;
   logic [1:0]  out_len, out_pfx_cnt;
   logic [63:0] out_imm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pmd_prefix_merge u0 (
      .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_words(win_words),
      .win_data(win_data), .out_vld(out_vld), .out_illegal(out_illegal),
      .out_len(out_len), .out_pfx_cnt(out_pfx_cnt), .out_imm(out_imm)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // R2: prefix opcode 8'hFB in bits [31:24]
   function automatic logic [31:0] mk_pfx(input logic [31:0] s);
      return {8'hFB, s[23:0]};
   endfunction
   function automatic logic [31:0] mk_base(input logic [31:0] s);
      return {(s[31:24] == 8'hFB) ? 8'h13 : s[31:24], s[23:0]};
   endfunction

   task automatic apply(input logic v, input logic [1:0] n, input logic [95:0] d);
      @(negedge clk);
      win_vld = v; win_words = n; win_data = d;
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic ev, input logic ei,
                             input logic [1:0] el, input logic [1:0] ec, input logic [63:0] em);
      chk({req, " vld"}, {63'd0, out_vld}, {63'd0, ev});
      chk({req, " illegal"}, {63'd0, out_illegal}, {63'd0, ei});
      chk({req, " len"}, {62'd0, out_len}, {62'd0, el});
      chk({req, " pfx_cnt"}, {62'd0, out_pfx_cnt}, {62'd0, ec});
      chk({req, " imm"}, out_imm, em);
   endtask

   initial begin
      logic [31:0] w [3];
      logic [31:0] seed;
      logic [35:0] v36;
      logic [59:0] v60;
      logic [63:0] eimm;
      logic [63:0] keep_imm;
      int c;
      bit found;
      string rq;

      repeat (3) @(negedge clk);
      expect_out("R1 reset", 1'b0, 1'b0, 2'd0, 2'd0, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1 after reset", 1'b0, 1'b0, 2'd0, 2'd0, 64'd0);

      seed = 32'h1234_5678;
      for (int vv = 0; vv < 6; vv++) begin
         for (int n = 0; n < 4; n++) begin
            for (int pat = 0; pat < 8; pat++) begin
               for (int i = 0; i < 3; i++) begin
                  seed = seed * 32'd1664525 + 32'd1013904223;
                  if (vv == 0) seed[31] = 1'b1;
                  if (vv == 1) seed[31] = 1'b0;
                  w[i] = pat[i] ? mk_pfx(seed ^ (seed << 7)) : mk_base(seed);
                  if (vv == 0) w[i][23] = 1'b1;
                  if (vv == 1) w[i][23] = 1'b0;
               end
               apply(1'b1, n[1:0], {w[2], w[1], w[0]});
               found = 1'b0; c = 0;
               for (int i = 0; i < 3; i++)
                  if (!found && i < n && !pat[i]) begin found = 1'b1; c = i; end
               if (!found) begin
                  rq = (n == 3) ? "R6" : "R7";
                  expect_out(rq, 1'b0, 1'b1, 2'd0, 2'd0, 64'd0);
               end else if (c == 0) begin
                  eimm = {{52{w[0][31]}}, w[0][31:20]};
                  expect_out("R3 R10", 1'b1, 1'b0, 2'd1, 2'd0, eimm);
               end else if (c == 1) begin
                  v36 = {w[0][23:0], w[1][31:20]};
                  eimm = {{28{v36[35]}}, v36};
                  expect_out("R4 R10", 1'b1, 1'b0, 2'd2, 2'd1, eimm);
               end else begin
                  v60 = {w[0][23:0], w[1][23:0], w[2][31:20]};
                  eimm = {{4{v60[59]}}, v60};
                  expect_out("R5", 1'b1, 1'b0, 2'd3, 2'd2, eimm);
               end
            end
         end
      end

      // R8: no window gives a quiet result
      apply(1'b0, 2'd3, {mk_base(32'h0), mk_pfx(32'h5), mk_pfx(32'h7)});
      expect_out("R8", 1'b0, 1'b0, 2'd0, 2'd0, 64'd0);

      // R10: trailing words after the base word change nothing
      apply(1'b1, 2'd3, {mk_pfx(32'hAAAA_AAAA), mk_base(32'h0123_4567), mk_pfx(32'h0080_0001)});
      keep_imm = out_imm;
      chk("R4 neg payload imm", out_imm, {{28{1'b1}}, 24'h800001, 12'h012});
      apply(1'b1, 2'd3, {mk_base(32'h5555_5555), mk_base(32'h0123_4567), mk_pfx(32'h0080_0001)});
      chk("R10 trailing word", out_imm, keep_imm);

      // R9: result follows the window of the previous edge only
      @(negedge clk);
      win_vld = 1'b1; win_words = 2'd1; win_data = {64'd0, mk_base(32'h7FF0_0000)};
      @(posedge clk); #1;
      win_vld = 1'b0;
      @(negedge clk);
      expect_out("R9 latency", 1'b1, 1'b0, 2'd1, 2'd0, 64'h0000_0000_0000_07FF);
      @(negedge clk);
      expect_out("R9 next idle", 1'b0, 1'b0, 2'd0, 2'd0, 64'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule